// File: doc/BRIEF.md
# Shadow-to-Physical Address Remapper

This block sits on the address path inside a memory controller. Each bus request carries a physical address. A fixed, aligned range of those addresses is not backed by memory; it is a shadow window. When a request falls inside the window, the block takes the page number, looks up a local table and replaces the page number with a real physical page. The 12-bit offset within the page is kept. Any address outside the window leaves the block unchanged.

Because of this second translation step, the operating system can place a contiguous, aligned run of shadow pages in a single large TLB entry. Each of those shadow pages can still point at a scattered real page. The processor's TLB, cache tags and bus traffic all carry the shadow address. Only this block knows where the data really lives.

Software installs and removes mappings through a single write port. A shadow request whose table entry is unmapped reports a fault and forwards no address. Every request, inside or outside the window, takes the same fixed two-cycle latency, so responses come out in request order.

Top module: `shadow_remapper`

## Requirements
- R1: After reset all outputs are low and every table entry is unmapped, so any shadow request faults until a mapping is written.
- R2: A request whose page number lies outside the window [WIN_BASE_FRAME, WIN_BASE_FRAME + 2^WIN_IDX_W) appears on rsp_addr unchanged, with rsp_valid=1, rsp_shadow=0 and rsp_fault=0, exactly two clock edges after the edge that sampled it.
- R3: A shadow request whose entry is mapped produces rsp_addr = {entry frame, request bits [11:0]}, with rsp_valid=1 and rsp_shadow=1, two edges after it was sampled. The entry index is page number minus WIN_BASE_FRAME, which is the low WIN_IDX_W bits of the page number.
- R4: A shadow request whose entry is unmapped produces rsp_fault=1, rsp_valid=0 and rsp_addr=0, with the same two-edge latency.
- R5: A table write sampled at the same edge as a lookup of that entry does not affect that lookup, which returns the old mapping. The next request sees the new mapping.
- R6: Each entry is independent. Consecutive shadow pages may map to unrelated, non-contiguous real pages.
- R7: A write with map_valid=0 removes the mapping, and later requests to that page fault.
- R8: A cycle with no request produces rsp_valid=0, rsp_fault=0 and rsp_addr=0 two edges later.
- R9: The page just below the window and the page just past its end both pass through unchanged. The first page of the window is treated as shadow.
- R10: rsp_valid and rsp_fault are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A bus address is presented this cycle |
| req_addr | input | 32 | Bus physical address |
| map_we | input | 1 | Write one table entry |
| map_idx | input | WIN_IDX_W (7) | Entry index (shadow page minus window base page) |
| map_valid | input | 1 | 1 installs the mapping, 0 removes it |
| map_frame | input | 20 | Real page number to install |
| rsp_valid | output | 1 | rsp_addr carries a real address |
| rsp_addr | output | 32 | Retranslated or passed-through address |
| rsp_shadow | output | 1 | The response came from the shadow window |
| rsp_fault | output | 1 | Shadow request hit an unmapped entry |

## Verification
Directed cases cover four situations: the worked shadow address translated through a known entry, four consecutive shadow pages pointed at scattered real pages, a write landing on the same edge as a lookup of that entry, and the three pages at the window boundaries. The same-edge case separates old-value from new-value read ordering. The boundary pages show whether the window compare is off by one. A seeded random stream then mixes requests inside and outside the window with random installs and removals, and checks every response against a bench-side table model. This stream distinguishes correct per-entry indexing from aliasing between entries, and catches faults or pass-throughs that carry the wrong address.

// File: rtl/shadow_remap_pkg.sv
package shadow_remap_pkg;

    localparam int ADDR_W  = 32;
    localparam int OFF_W   = 12;
    localparam int FRAME_W = ADDR_W - OFF_W;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [FRAME_W-1:0] frame_t;

    // One table slot: a mapped flag plus the real page it points at
    typedef struct packed {
        logic   mapped;
        frame_t frame;
    } map_entry_t;

    // First stage: request after classification and table read
    typedef struct packed {
        logic       valid;
        logic       shadow;
        map_entry_t entry;
        addr_t      addr;
    } lookup_t;

    // Second stage: the registered response
    typedef struct packed {
        logic  valid;
        logic  fault;
        logic  shadow;
        addr_t addr;
    } resp_t;

    typedef struct packed {
        lookup_t lk;
        resp_t   rs;
    } pipe_t;

endpackage

// File: rtl/srm_window_decode.sv
module srm_window_decode
    import shadow_remap_pkg::*;
#(
    parameter frame_t WIN_BASE_FRAME = 20'h80200,
    parameter int     WIN_IDX_W      = 7
) (
    input  addr_t                addr,
    output logic                 in_window,
    output logic [WIN_IDX_W-1:0] idx
);
    localparam int TAG_W = FRAME_W - WIN_IDX_W;
    localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE_FRAME[FRAME_W-1:WIN_IDX_W];

    // The window is aligned to its size, so membership is a compare of the
    // upper page bits and the entry index is the remaining low page bits.
    always_comb begin
        in_window = (addr[ADDR_W-1:OFF_W+WIN_IDX_W] == WIN_TAG);
        idx       = addr[OFF_W+WIN_IDX_W-1:OFF_W];
    end

endmodule

// File: rtl/srm_map_table.sv
module srm_map_table
    import shadow_remap_pkg::*;
#(
    parameter int WIN_IDX_W = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [WIN_IDX_W-1:0] wr_idx,
    input  map_entry_t           wr_entry,
    input  logic [WIN_IDX_W-1:0] rd_idx,
    output map_entry_t           rd_entry
);
    localparam int DEPTH = 1 << WIN_IDX_W;

    map_entry_t tab_d [DEPTH];
    map_entry_t tab_q [DEPTH];

    always_comb begin
        tab_d = tab_q;
        if (wr_en) begin
            tab_d[wr_idx] = wr_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tab_q <= '{default: '0};
        end else begin
            tab_q <= tab_d;
        end
    end

    // Read from the registered array: a write on the same edge is not seen yet
    assign rd_entry = tab_q[rd_idx];

endmodule

// File: rtl/shadow_remapper.sv
module shadow_remapper
    import shadow_remap_pkg::*;
#(
    parameter frame_t WIN_BASE_FRAME = 20'h80200,
    parameter int     WIN_IDX_W      = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [31:0]          req_addr,
    input  logic                 map_we,
    input  logic [WIN_IDX_W-1:0] map_idx,
    input  logic                 map_valid,
    input  logic [19:0]          map_frame,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_addr,
    output logic                 rsp_shadow,
    output logic                 rsp_fault
);
    logic                 in_window;
    logic [WIN_IDX_W-1:0] look_idx;
    map_entry_t           look_entry;
    map_entry_t           wr_entry;

    pipe_t pipe_d, pipe_q;

    srm_window_decode #(
        .WIN_BASE_FRAME(WIN_BASE_FRAME),
        .WIN_IDX_W     (WIN_IDX_W)
    ) u_decode (
        .addr     (req_addr),
        .in_window(in_window),
        .idx      (look_idx)
    );

    assign wr_entry = '{mapped: map_valid, frame: map_frame};

    srm_map_table #(
        .WIN_IDX_W(WIN_IDX_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (map_we),
        .wr_idx  (map_idx),
        .wr_entry(wr_entry),
        .rd_idx  (look_idx),
        .rd_entry(look_entry)
    );

    always_comb begin
        pipe_d = pipe_q;

        // Stage 1: classify and capture the table entry
        pipe_d.lk.valid  = req_valid;
        pipe_d.lk.shadow = req_valid & in_window;
        pipe_d.lk.entry  = look_entry;
        pipe_d.lk.addr   = req_valid ? req_addr : '0;

        // Stage 2: form the response
        pipe_d.rs = '0;
        if (pipe_q.lk.valid) begin
            if (!pipe_q.lk.shadow) begin
                pipe_d.rs.valid = 1'b1;
                pipe_d.rs.addr  = pipe_q.lk.addr;
            end else if (pipe_q.lk.entry.mapped) begin
                pipe_d.rs.valid  = 1'b1;
                pipe_d.rs.shadow = 1'b1;
                pipe_d.rs.addr   = {pipe_q.lk.entry.frame, pipe_q.lk.addr[OFF_W-1:0]};
            end else begin
                pipe_d.rs.fault  = 1'b1;
                pipe_d.rs.shadow = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign rsp_valid  = pipe_q.rs.valid;
    assign rsp_addr   = pipe_q.rs.addr;
    assign rsp_shadow = pipe_q.rs.shadow;
    assign rsp_fault  = pipe_q.rs.fault;

endmodule

// File: rtl/srm_checker.sv
module srm_checker #(
    parameter logic [19:0] WIN_BASE_FRAME = 20'h80200,
    parameter int          WIN_IDX_W      = 7
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        rsp_valid,
    input logic [31:0] rsp_addr,
    input logic        rsp_shadow,
    input logic        rsp_fault
);
    localparam logic [20:0] WIN_END = {1'b0, WIN_BASE_FRAME} + (21'd1 << WIN_IDX_W);

    logic        h1_v, h2_v, h1_w, h2_w;
    logic [31:0] h1_a, h2_a;
    logic        cur_w;

    // Range compare, written independently of the design's tag compare
    assign cur_w = ({1'b0, req_addr[31:12]} >= {1'b0, WIN_BASE_FRAME}) &&
                   ({1'b0, req_addr[31:12]} < WIN_END);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h1_v <= 1'b0; h2_v <= 1'b0;
            h1_w <= 1'b0; h2_w <= 1'b0;
            h1_a <= '0;   h2_a <= '0;
        end else begin
            h1_v <= req_valid; h2_v <= h1_v;
            h1_w <= cur_w;     h2_w <= h1_w;
            h1_a <= req_addr;  h2_a <= h1_a;
        end
    end

    assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (h2_v && !h2_w) |-> (rsp_valid && !rsp_shadow && !rsp_fault && rsp_addr == h2_a));

    assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (h2_v && h2_w && rsp_valid) |-> (rsp_shadow && rsp_addr[11:0] == h2_a[11:0]));

    assert_fault_no_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_addr == 32'd0 && rsp_shadow && h2_v && h2_w));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !h2_v |-> (!rsp_valid && !rsp_fault && rsp_addr == 32'd0));

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_fault));

endmodule

bind shadow_remapper srm_checker #(
    .WIN_BASE_FRAME(WIN_BASE_FRAME),
    .WIN_IDX_W     (WIN_IDX_W)
) u_srm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_addr  (rsp_addr),
    .rsp_shadow(rsp_shadow),
    .rsp_fault (rsp_fault)
);

// File: tb/tb_shadow_remapper.sv
module tb_shadow_remapper;
    localparam int          CLK_PERIOD = 10;
    localparam logic [19:0] BASE       = 20'h80200;
    localparam int          IDX_W      = 7;
    localparam int          DEPTH      = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_valid;
    logic [31:0]      req_addr;
    logic             map_we;
    logic [IDX_W-1:0] map_idx;
    logic             map_valid;
    logic [19:0]      map_frame;
    logic             rsp_valid;
    logic [31:0]      rsp_addr;
    logic             rsp_shadow;
    logic             rsp_fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic        v;
        logic        f;
        logic        s;
        logic [31:0] a;
        string       tag;
    } exp_t;

    logic        mdl_mapped [DEPTH];
    logic [19:0] mdl_frame  [DEPTH];
    exp_t        prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    shadow_remapper #(.WIN_BASE_FRAME(BASE), .WIN_IDX_W(IDX_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr),
        .map_we(map_we), .map_idx(map_idx), .map_valid(map_valid), .map_frame(map_frame),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_shadow(rsp_shadow), .rsp_fault(rsp_fault)
    );

    function automatic bit in_win(input logic [31:0] a);
        return (a[31:12] >= BASE) && (a[31:12] < BASE + 20'(DEPTH));
    endfunction

    function automatic exp_t predict(input logic rv, input logic [31:0] a);
        exp_t e;
        int   i;
        e = '{v: 1'b0, f: 1'b0, s: 1'b0, a: 32'd0, tag: "R8"};
        if (rv) begin
            if (!in_win(a)) begin
                e.v = 1'b1; e.a = a; e.tag = "R2";
            end else begin
                i = int'(a[31:12] - BASE);
                e.s = 1'b1;
                if (mdl_mapped[i]) begin
                    e.v = 1'b1; e.a = {mdl_frame[i], a[11:0]}; e.tag = "R3";
                end else begin
                    e.f = 1'b1; e.tag = "R4";
                end
            end
        end
        return e;
    endfunction

    task automatic check_out(input exp_t e);
        checks++;
        if (rsp_valid !== e.v || rsp_fault !== e.f || rsp_shadow !== e.s || rsp_addr !== e.a) begin
            fails++;
            $display("FAIL %s: got v=%0b f=%0b s=%0b a=%h, expected v=%0b f=%0b s=%0b a=%h",
                     e.tag, rsp_valid, rsp_fault, rsp_shadow, rsp_addr, e.v, e.f, e.s, e.a);
        end
    endtask

    // One clock: drive, predict with the table as it stands before this edge,
    // update the model, then check the response of the previous call's request.
    task automatic cycle(input logic rv, input logic [31:0] a, input logic we,
                         input logic [IDX_W-1:0] wi, input logic wm,
                         input logic [19:0] wf, input string tag);
        exp_t cur;
        req_valid = rv; req_addr = a;
        map_we = we; map_idx = wi; map_valid = wm; map_frame = wf;
        cur = predict(rv, a);
        if (tag != "") cur.tag = tag;
        if (we) begin
            mdl_mapped[int'(wi)] = wm;
            mdl_frame[int'(wi)]  = wf;
        end
        @(posedge clk); #1;
        check_out(prev);
        prev = cur;
    endtask

    task automatic idle(input string tag);
        cycle(1'b0, 32'd0, 1'b0, '0, 1'b0, 20'd0, tag);
    endtask

    task automatic wr(input logic [IDX_W-1:0] wi, input logic wm, input logic [19:0] wf);
        cycle(1'b0, 32'd0, 1'b1, wi, wm, wf, "R8");
    endtask

    task automatic rd(input logic [31:0] a, input string tag);
        cycle(1'b1, a, 1'b0, '0, 1'b0, 20'd0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) begin
            mdl_mapped[i] = 1'b0;
            mdl_frame[i]  = 20'd0;
        end
        rst_n = 1'b0;
        req_valid = 1'b0; req_addr = '0;
        map_we = 1'b0; map_idx = '0; map_valid = 1'b0; map_frame = '0;
        repeat (3) @(posedge clk);
        #1;
        prev = '{v: 1'b0, f: 1'b0, s: 1'b0, a: 32'd0, tag: "R1"};
        check_out(prev);               // R1: outputs low during reset
        rst_n = 1'b1;

        // R1: nothing mapped after reset
        rd(32'h8024_0080, "R1");
        idle("R1");

        // R3: the worked example
        wr(7'h40, 1'b1, 20'h40138);
        rd(32'h8024_0080, "R3");

        // R6: consecutive shadow pages to scattered real pages
        wr(7'h41, 1'b1, 20'h04012);
        wr(7'h42, 1'b1, 20'h06155);
        wr(7'h43, 1'b1, 20'h20285);
        rd(32'h8024_1abc, "R6");
        rd(32'h8024_2004, "R6");
        rd(32'h8024_3ffc, "R6");
        rd(32'h8024_0000, "R6");

        // R5: write on the same edge as lookup returns the old mapping, then new
        cycle(1'b1, 32'h8024_0abc, 1'b1, 7'h40, 1'b1, 20'h12345, "R5");
        rd(32'h8024_0abc, "R5");

        // R7: removing a mapping makes the page fault
        wr(7'h41, 1'b0, 20'h00000);
        rd(32'h8024_1abc, "R7");
        rd(32'h8024_2004, "R7");

        // R9: window edges
        rd(32'h801F_F123, "R9");
        rd(32'h8028_0456, "R9");
        rd(32'h8020_0000, "R9");
        wr(7'h7F, 1'b1, 20'hABCDE);
        rd(32'h8027_F010, "R9");

        // R8: idle cycles give quiet outputs
        idle("R8");
        idle("R8");

        // Random mix; R10 holds because each check compares both flags
        for (int n = 0; n < 4000; n++) begin
            logic        rv, we, wm;
            logic [31:0] a;
            logic [6:0]  wi;
            logic [19:0] wf;
            rv = ($urandom_range(0, 9) < 8);
            if ($urandom_range(0, 9) < 6)
                a = {BASE[19:7], 7'($urandom_range(0, DEPTH - 1)), 12'($urandom)};
            else
                a = $urandom;
            we = ($urandom_range(0, 9) < 3);
            wi = 7'($urandom_range(0, DEPTH - 1));
            wm = ($urandom_range(0, 3) != 0);
            wf = 20'($urandom);
            cycle(rv, a, we, wi, wm, wf, "");
        end

        idle("R8");
        idle("R8");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule